// File: doc/BRIEF.md
# Bus-Lock Prefix Legality Checker

This block sits beside the instruction decoder and rules on every instruction that arrives with a bus-lock prefix. It looks at the primary opcode byte, the escape flag for the two-byte opcode map, the ModR/M byte and the repeat-prefix flag. From these it decides whether the instruction is one of the few memory-destination read-modify-write forms that may hold the bus for the whole access.

When the form qualifies, the block raises a lock-enable flag for the execution unit. When it does not, the block raises an invalid-opcode fault and reports vector 6. The ruling does not depend on privilege: no privilege level is an input, and no privilege level can change the result. Instructions without the prefix pass through with neither flag set. Each ruling is registered and comes out one clock after the input strobe, together with a one-cycle done pulse.

Top module: `lock_guard`

## Requirements
- R1: Each cycle with `in_valid` high produces `done` high in the next cycle, and only then. While `done` is low, `lock_en`, `fault` and `fault_vec` are all zero. Strobes in consecutive cycles give consecutive rulings.
- R2: With `lock_pfx` low, the ruling sets neither `lock_en` nor `fault`, whatever the opcode, ModR/M or repeat flag.
- R3: In the one-byte map (`two_byte` low), the arithmetic/logic memory-destination opcodes 00h, 01h, 08h, 09h, 10h, 11h, 18h, 19h, 20h, 21h, 28h, 29h, 30h and 31h are granted. The register-destination forms (for example 02h) and the compare forms 38h/39h fault.
- R4: The one-byte immediate group 80h–83h is granted for a ModR/M reg field (bits 5:3) of 0 to 6. Reg field 7 (compare) faults.
- R5: The exchange opcodes 86h and 87h with a memory operand are granted.
- R6: Group F6h/F7h is granted only for reg field 2 or 3. Group FEh/FFh is granted only for reg field 0 or 1. Other reg values in these groups fault.
- R7: In the two-byte map (`two_byte` high), the opcodes ABh, B3h and BBh are granted, and BAh is granted for reg field 5, 6 or 7. A3h, BAh with reg field 4, and any other two-byte opcode fault. The same byte values in the one-byte map fault.
- R8: A ModR/M mod field (bits 7:6) equal to 11b makes any locked form fault, including forms that are otherwise granted.
- R9: A repeat prefix together with the lock prefix always faults.
- R10: When `fault` is high, `fault_vec` equals 6; otherwise it is 0. `lock_en` and `fault` are never high together, and a locked ruling sets exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction fields valid this cycle |
| lock_pfx | input | 1 | Bus-lock prefix present |
| two_byte | input | 1 | Opcode is from the two-byte (escape) map |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModR/M byte: mod in bits 7:6, reg in bits 5:3 |
| rep_pfx | input | 1 | Repeat prefix present |
| lock_en | output | 1 | Locked read-modify-write granted |
| fault | output | 1 | Invalid-opcode fault raised |
| fault_vec | output | 8 | Fault vector number (6 when faulting) |
| done | output | 1 | Ruling valid this cycle |

## Verification
A wrong entry in either opcode map shows at the ports as a grant where a fault was due, or the reverse, in the cycle after that opcode is strobed. The directed tests cover every granted byte and the neighbours that must trap, so such an error shows up one clock after the input. A broken gate on the memory operand or on the repeat prefix shows in the same way, as a granted ruling one cycle after a register-mode or repeated input. A fault in the result register shows as a missing or stretched done pulse, or as flags that stay set while done is low, on the very next edge.

// File: rtl/lock_guard_pkg.sv
// Shared types for the bus-lock legality checker.
// Assumes ModR/M layout: mod in [7:6], reg in [5:3], r/m in [2:0].
package lock_guard_pkg;

    // Outcome of a ruling on one instruction.
    typedef enum logic [1:0] {
        RULE_NONE  = 2'd0,
        RULE_GRANT = 2'd1,
        RULE_TRAP  = 2'd2
    } rule_e;

    // Split view of the addressing byte.
    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] sel;
        logic [2:0] base;
    } addr_byte_t;

    localparam logic [1:0] MODE_REGISTER = 2'b11;

endpackage

// File: rtl/lock_map_primary.sv
// Decides whether a one-byte-map opcode is a lockable read-modify-write form.
// Memory-operand and prefix checks are made elsewhere; this module looks only
// at the opcode byte and the reg field of the addressing byte.
module lock_map_primary #(
    parameter int OP_W  = 8,
    parameter int SEL_W = 3
) (
    input  logic [OP_W-1:0]  op,
    input  logic [SEL_W-1:0] sel,
    output logic             form_ok
);
    localparam int ALU_ROWS = 7;

    logic [ALU_ROWS-1:0] alu_hit;
    logic                imm_hit;
    logic                xchg_hit;
    logic                neg_hit;
    logic                step_hit;

    // One comparator per arithmetic row: memory-destination byte or word form.
    for (genvar g = 0; g < ALU_ROWS; g++) begin : g_alu_row
        localparam logic [OP_W-1:0] ROW_BASE = OP_W'(g * 8);
        assign alu_hit[g] = (op[OP_W-1:1] == ROW_BASE[OP_W-1:1]);
    end

    // Group decodes that need the reg field of the addressing byte.
    always_comb begin
        imm_hit  = (op[OP_W-1:2] == 6'b100000) && (sel != 3'd7);
        xchg_hit = (op[OP_W-1:1] == 7'b1000011);
        neg_hit  = (op[OP_W-1:1] == 7'b1111011) && (sel[2:1] == 2'b01);
        step_hit = (op[OP_W-1:1] == 7'b1111111) && (sel[2:1] == 2'b00);
    end

    // Combine all granted families.
    assign form_ok = (|alu_hit) | imm_hit | xchg_hit | neg_hit | step_hit;

endmodule

// File: rtl/lock_map_escape.sv
// Decides whether a two-byte-map opcode is a lockable bit-modify form.
// Plain bit test does not write memory and is never granted.
module lock_map_escape #(
    parameter int OP_W  = 8,
    parameter int SEL_W = 3
) (
    input  logic [OP_W-1:0]  op,
    input  logic [SEL_W-1:0] sel,
    output logic             form_ok
);
    logic reg_form;
    logic imm_form;

    // Register-source bit set, reset and complement.
    always_comb begin
        reg_form = (op == 8'hAB) || (op == 8'hB3) || (op == 8'hBB);
    end

    // Immediate-source bit group; reg 5..7 modify memory, reg 4 only tests.
    always_comb begin
        imm_form = (op == 8'hBA) && (sel >= 3'd5);
    end

    assign form_ok = reg_form | imm_form;

endmodule

// File: rtl/lock_judge.sv
// Merges the map result with the memory-operand and repeat-prefix gates
// into one ruling. Combinational; the result is registered by the caller.
module lock_judge
    import lock_guard_pkg::*;
(
    input  logic       lock_pfx,
    input  logic       rep_pfx,
    input  logic [1:0] mode,
    input  logic       form_ok,
    output rule_e      rule
);
    logic mem_operand;

    // A register-mode operand gives no memory access to lock.
    assign mem_operand = (mode != MODE_REGISTER);

    // Priority: no prefix first, then repeat and operand gates, then the map.
    always_comb begin
        if (!lock_pfx) begin
            rule = RULE_NONE;
        end else if (rep_pfx || !mem_operand || !form_ok) begin
            rule = RULE_TRAP;
        end else begin
            rule = RULE_GRANT;
        end
    end

endmodule

// File: rtl/lock_result_reg.sv
// Holds one ruling for one cycle, with a done pulse that follows each strobe.
// Outputs are zero in any cycle without a ruling.
module lock_result_reg
    import lock_guard_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int FAULT_NUM = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  rule_e            rule,
    output logic             lock_en,
    output logic             fault,
    output logic [VEC_W-1:0] fault_vec,
    output logic             done
);
    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FAULT_NUM);

    // Capture the ruling on the strobe and clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            lock_en   <= 1'b0;
            fault     <= 1'b0;
            fault_vec <= '0;
        end else begin
            done      <= strobe;
            lock_en   <= strobe && (rule == RULE_GRANT);
            fault     <= strobe && (rule == RULE_TRAP);
            fault_vec <= (strobe && (rule == RULE_TRAP)) ? VEC_VAL : '0;
        end
    end

endmodule

// File: rtl/lock_guard.sv
// Top of the bus-lock legality checker. Chooses the opcode map, gates on
// operand mode and repeat prefix, and registers the ruling.
// Assumes all inputs are stable and meaningful only while in_valid is high.
module lock_guard
    import lock_guard_pkg::*;
#(
    parameter int OP_W      = 8,
    parameter int VEC_W     = 8,
    parameter int FAULT_NUM = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             lock_pfx,
    input  logic             two_byte,
    input  logic [OP_W-1:0]  opcode,
    input  logic [7:0]       modrm,
    input  logic             rep_pfx,
    output logic             lock_en,
    output logic             fault,
    output logic [VEC_W-1:0] fault_vec,
    output logic             done
);
    addr_byte_t ab;
    logic       prim_ok;
    logic       esc_ok;
    logic       form_ok;
    rule_e      rule;
    logic       unused_base;

    assign ab          = addr_byte_t'(modrm);
    assign unused_base = ^ab.base;

    lock_map_primary #(.OP_W(OP_W), .SEL_W(3)) u_prim (
        .op      (opcode),
        .sel     (ab.sel),
        .form_ok (prim_ok)
    );

    lock_map_escape #(.OP_W(OP_W), .SEL_W(3)) u_esc (
        .op      (opcode),
        .sel     (ab.sel),
        .form_ok (esc_ok)
    );

    // Pick the map named by the escape flag.
    assign form_ok = two_byte ? esc_ok : prim_ok;

    lock_judge u_judge (
        .lock_pfx (lock_pfx),
        .rep_pfx  (rep_pfx),
        .mode     (ab.mode),
        .form_ok  (form_ok),
        .rule     (rule)
    );

    lock_result_reg #(.VEC_W(VEC_W), .FAULT_NUM(FAULT_NUM)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (in_valid),
        .rule      (rule),
        .lock_en   (lock_en),
        .fault     (fault),
        .fault_vec (fault_vec),
        .done      (done)
    );

endmodule

// File: rtl/lock_guard_chk.sv
// Port-level properties of the bus-lock legality checker, bound to the top.
module lock_guard_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             lock_pfx,
    input logic [1:0]       mode,
    input logic             rep_pfx,
    input logic             lock_en,
    input logic             fault,
    input logic [VEC_W-1:0] fault_vec,
    input logic             done
);
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);                                           // R1
    AST_DONE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);                                         // R1
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!lock_en && !fault && fault_vec == '0));           // R1
    AST_NO_PREFIX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lock_pfx) |=> (!lock_en && !fault));            // R2
    AST_REG_MODE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lock_pfx && mode == 2'b11) |=> fault);           // R8
    AST_REP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lock_pfx && rep_pfx) |=> fault);                 // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lock_pfx) |=> $onehot({lock_en, fault}));        // R10
    AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_vec == VEC_W'(6)));                          // R10
endmodule

bind lock_guard lock_guard_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lock_pfx  (lock_pfx),
    .mode      (modrm[7:6]),
    .rep_pfx   (rep_pfx),
    .lock_en   (lock_en),
    .fault     (fault),
    .fault_vec (fault_vec),
    .done      (done)
);

// File: tb/sim_lock_guard.sv
`timescale 1ns/1ps
module sim_lock_guard;
    localparam int EXP_NONE  = 0;
    localparam int EXP_GRANT = 1;
    localparam int EXP_TRAP  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       lock_pfx = 1'b0;
    logic       two_byte = 1'b0;
    logic [7:0] opcode = '0;
    logic [7:0] modrm = '0;
    logic       rep_pfx = 1'b0;
    logic       lock_en;
    logic       fault;
    logic [7:0] fault_vec;
    logic       done;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    lock_guard u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lock_pfx(lock_pfx),
        .two_byte(two_byte), .opcode(opcode), .modrm(modrm), .rep_pfx(rep_pfx),
        .lock_en(lock_en), .fault(fault), .fault_vec(fault_vec), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge, check its ruling one edge later.
    task automatic issue(input bit tb, input logic [7:0] op, input logic [7:0] mr,
                         input bit lk, input bit rp, input int exp, input string req);
        in_valid = 1'b1; two_byte = tb; opcode = op; modrm = mr;
        lock_pfx = lk; rep_pfx = rp;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, {req, " done"}, done, 1);
        check(lock_en == (exp == EXP_GRANT), {req, " lock_en"}, lock_en, exp == EXP_GRANT);
        check(fault == (exp == EXP_TRAP), {req, " fault"}, fault, exp == EXP_TRAP);
        check(fault_vec == ((exp == EXP_TRAP) ? 8'd6 : 8'd0), {req, " vec (R10)"},
              fault_vec, (exp == EXP_TRAP) ? 6 : 0);
        in_valid = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(posedge clk);
        @(negedge clk);
        check(!done && !lock_en && !fault && fault_vec == 0, req,
              {done, lock_en, fault, fault_vec}, 0);
    endtask

    task automatic t_reset();
        check(!done && !lock_en && !fault && fault_vec == 0, "R1 reset",
              {done, lock_en, fault, fault_vec}, 0);
    endtask

    task automatic t_no_prefix();
        issue(0, 8'h00, 8'h00, 0, 0, EXP_NONE, "R2 add no prefix");
        issue(0, 8'h38, 8'hC0, 0, 1, EXP_NONE, "R2 cmp reg rep no prefix");
    endtask

    task automatic t_alu();
        for (int r = 0; r < 7; r++) begin
            issue(0, 8'(r * 8), 8'h06, 1, 0, EXP_GRANT, "R3 alu byte");
            issue(0, 8'(r * 8 + 1), 8'h46, 1, 0, EXP_GRANT, "R3 alu word");
        end
        issue(0, 8'h02, 8'h06, 1, 0, EXP_TRAP, "R3 reg destination");
        issue(0, 8'h38, 8'h06, 1, 0, EXP_TRAP, "R3 cmp");
        issue(0, 8'h39, 8'h06, 1, 0, EXP_TRAP, "R3 cmp word");
    endtask

    task automatic t_imm_group();
        for (int op = 8'h80; op <= 8'h83; op++) begin
            for (int s = 0; s < 8; s++) begin
                issue(0, 8'(op), {2'b00, 3'(s), 3'b110}, 1, 0,
                      (s == 7) ? EXP_TRAP : EXP_GRANT, "R4 imm group");
            end
        end
    endtask

    task automatic t_xchg();
        issue(0, 8'h86, 8'h47, 1, 0, EXP_GRANT, "R5 xchg byte");
        issue(0, 8'h87, 8'h8B, 1, 0, EXP_GRANT, "R5 xchg word");
    endtask

    task automatic t_unary();
        for (int s = 0; s < 8; s++) begin
            issue(0, 8'hF6, {2'b00, 3'(s), 3'b011}, 1, 0,
                  (s == 2 || s == 3) ? EXP_GRANT : EXP_TRAP, "R6 F6 group");
            issue(0, 8'hFF, {2'b10, 3'(s), 3'b001}, 1, 0,
                  (s == 0 || s == 1) ? EXP_GRANT : EXP_TRAP, "R6 FF group");
        end
        issue(0, 8'hF7, 8'h18, 1, 0, EXP_GRANT, "R6 F7 neg");
        issue(0, 8'hFE, 8'h00, 1, 0, EXP_GRANT, "R6 FE inc");
    endtask

    task automatic t_escape();
        issue(1, 8'hAB, 8'h05, 1, 0, EXP_GRANT, "R7 bts");
        issue(1, 8'hB3, 8'h05, 1, 0, EXP_GRANT, "R7 btr");
        issue(1, 8'hBB, 8'h05, 1, 0, EXP_GRANT, "R7 btc");
        for (int s = 0; s < 8; s++) begin
            issue(1, 8'hBA, {2'b01, 3'(s), 3'b000}, 1, 0,
                  (s >= 5) ? EXP_GRANT : EXP_TRAP, "R7 BA group");
        end
        issue(1, 8'hA3, 8'h05, 1, 0, EXP_TRAP, "R7 plain bt");
        issue(1, 8'h00, 8'h05, 1, 0, EXP_TRAP, "R7 other escape");
        issue(0, 8'hAB, 8'h05, 1, 0, EXP_TRAP, "R7 one-byte AB");
        issue(1, 8'h86, 8'h05, 1, 0, EXP_TRAP, "R7 escape 86");
    endtask

    task automatic t_reg_mode();
        issue(0, 8'h00, 8'hC1, 1, 0, EXP_TRAP, "R8 add reg");
        issue(0, 8'h87, 8'hD8, 1, 0, EXP_TRAP, "R8 xchg reg");
        issue(1, 8'hAB, 8'hC3, 1, 0, EXP_TRAP, "R8 bts reg");
        issue(0, 8'hFE, 8'hC0, 1, 0, EXP_TRAP, "R8 inc reg");
    endtask

    task automatic t_rep();
        issue(0, 8'h00, 8'h06, 1, 1, EXP_TRAP, "R9 rep add");
        issue(1, 8'hBA, 8'h68, 1, 1, EXP_TRAP, "R9 rep bts imm");
    endtask

    task automatic t_pulse();
        issue(0, 8'h86, 8'h00, 1, 0, EXP_GRANT, "R1 single strobe");
        idle_check("R1 done drops");
        issue(0, 8'h38, 8'h00, 1, 0, EXP_TRAP, "R1 back to back a");
        issue(0, 8'h30, 8'h00, 1, 0, EXP_GRANT, "R1 back to back b");
        issue(0, 8'h02, 8'h00, 0, 0, EXP_NONE, "R1 back to back c");
        idle_check("R1 idle after burst");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_prefix();
        t_alu();
        t_imm_group();
        t_xchg();
        t_unary();
        t_escape();
        t_reg_mode();
        t_rep();
        t_pulse();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule